// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division over several cycles. Its results go to a private pair of result registers, HI and LO, and not to a general destination. The caller issues a start pulse together with a two-bit operation code and two operands. The unit reports busy while it works. When the work finishes, it writes both result registers in the same cycle.

A multiply places the upper half of its 64-bit product in HI and the lower half in LO. A divide places the remainder in HI and the quotient in LO. Multiplication uses a shift-add loop and division uses a restoring shift-subtract loop. Both loops run on operand magnitudes, and the signs are applied in a final fix-up cycle. The surrounding pipeline reads HI or LO through two request lines and one shared data output. A request made while the unit is busy returns the last completed values and raises a stall flag.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, busy and stall are low, and a read of HI or of LO returns zero.
- R2: The operation code selects the operation: 00 is signed multiply, 01 is unsigned multiply, 10 is signed divide and 11 is unsigned divide. These codes are the two low bits of the function codes 011000 to 011011. A multiply writes bits 63..32 of the product to HI and bits 31..0 to LO.
- R3: An unsigned divide writes a/b to LO and a%b to HI.
- R4: A signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend. The case -2^31 / -1 yields LO = 0x80000000 and HI = 0.
- R5: A divide by zero, signed or unsigned, completes without any trap and leaves HI equal to the dividend and LO equal to all ones.
- R6: A start accepted while idle raises busy in the next cycle. Busy then stays high for exactly W+1 cycles: W iterations plus one fix-up cycle.
- R7: A start pulse while busy is ignored. The running operation keeps its operands and its latency, and no second operation follows it.
- R8: With rd_hi_i high the data output shows HI. With only rd_lo_i high it shows LO. With neither high it shows zero.
- R9: A read request while busy returns the previously completed HI or LO value and raises stall_o. stall_o is low whenever there is no read request or the unit is idle.
- R10: HI and LO change only at the end of an operation, in the cycle in which busy falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| op_i | input | 2 | Operation code (see R2) |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| rd_hi_i | input | 1 | Request to read HI |
| rd_lo_i | input | 1 | Request to read LO |
| busy_o | output | 1 | Operation in progress |
| stall_o | output | 1 | Read requested while busy |
| rdata_o | output | 32 | Selected HI or LO value |

## Verification
The checker assumes that operands and the operation code are sampled only in the cycle in which a start is accepted, so it captures them in that cycle rather than relying on them staying stable. It also assumes a read request is a level that may be held for several cycles, so it checks for a stable output only when the same request is held in consecutive busy cycles. The stimulus changes operands only in a start cycle or while the unit is busy. In particular, the deliberately ignored start pulse carries different operands, which exposes any capture made outside the idle state.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_MULU = 2'b01,
        OP_DIV  = 2'b10,
        OP_DIVU = 2'b11
    } mdu_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_RUN  = 2'b01,
        PH_FIX  = 2'b10
    } mdu_phase_e;

endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  mdu_op_e        op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   mag_a_o,
    output logic [W-1:0]   mag_b_o,
    output logic           neg_main_o,
    output logic           neg_a_o,
    output logic           b_zero_o
);

    logic is_signed;
    logic sa;
    logic sb;

    always_comb begin
        is_signed  = (op_i == OP_MUL) || (op_i == OP_DIV);
        sa         = is_signed & a_i[W-1];
        sb         = is_signed & b_i[W-1];
        mag_a_o    = sa ? (~a_i + 1'b1) : a_i;
        mag_b_o    = sb ? (~b_i + 1'b1) : b_i;
        neg_main_o = sa ^ sb;
        neg_a_o    = sa;
        b_zero_o   = (b_i == '0);
    end

endmodule

// File: rtl/mdu_iter_step.sv
module mdu_iter_step #(
    parameter int W = 32
) (
    input  logic           is_div_i,
    input  logic [W-1:0]   acc_i,
    input  logic [W-1:0]   low_i,
    input  logic [W-1:0]   opnd_i,
    output logic [W-1:0]   acc_o,
    output logic [W-1:0]   low_o
);

    logic [W:0] sum;
    logic [W:0] rsh;
    logic [W:0] trial;

    always_comb begin
        sum   = {1'b0, acc_i} + (low_i[0] ? {1'b0, opnd_i} : '0);
        rsh   = {acc_i, low_i[W-1]};
        trial = rsh - {1'b0, opnd_i};
        if (is_div_i) begin
            if (!trial[W]) begin
                acc_o = trial[W-1:0];
                low_o = {low_i[W-2:0], 1'b1};
            end else begin
                acc_o = rsh[W-1:0];
                low_o = {low_i[W-2:0], 1'b0};
            end
        end else begin
            acc_o = sum[W:1];
            low_o = {sum[0], low_i[W-1:1]};
        end
    end

endmodule

// File: rtl/mdu_result_fix.sv
module mdu_result_fix #(
    parameter int W = 32
) (
    input  logic           is_div_i,
    input  logic           neg_main_i,
    input  logic           neg_a_i,
    input  logic           b_zero_i,
    input  logic [W-1:0]   a_orig_i,
    input  logic [W-1:0]   acc_i,
    input  logic [W-1:0]   low_i,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   lo_o
);

    logic [2*W-1:0] prod;
    logic [2*W-1:0] prod_s;

    always_comb begin
        prod   = {acc_i, low_i};
        prod_s = neg_main_i ? (~prod + 1'b1) : prod;
        if (!is_div_i) begin
            hi_o = prod_s[2*W-1:W];
            lo_o = prod_s[W-1:0];
        end else if (b_zero_i) begin
            hi_o = a_orig_i;
            lo_o = '1;
        end else begin
            hi_o = neg_a_i    ? (~acc_i + 1'b1) : acc_i;
            lo_o = neg_main_i ? (~low_i + 1'b1) : low_i;
        end
    end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [1:0]     op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           rd_hi_i,
    input  logic           rd_lo_i,
    output logic           busy_o,
    output logic           stall_o,
    output logic [W-1:0]   rdata_o
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        mdu_phase_e     ph;
        logic [CW-1:0]  cnt;
        logic           is_div;
        logic           neg_main;
        logic           neg_a;
        logic           bz;
        logic [W-1:0]   a_orig;
        logic [W-1:0]   acc;
        logic [W-1:0]   low;
        logic [W-1:0]   opnd;
        logic [W-1:0]   hi;
        logic [W-1:0]   lo;
    } mdu_state_t;

    mdu_state_t st_d;
    mdu_state_t st_q;

    mdu_op_e      op_e;
    logic [W-1:0] mag_a;
    logic [W-1:0] mag_b;
    logic         p_neg_main;
    logic         p_neg_a;
    logic         p_bz;
    logic [W-1:0] step_acc;
    logic [W-1:0] step_low;
    logic [W-1:0] fix_hi;
    logic [W-1:0] fix_lo;
    logic [W-1:0] hi_q;
    logic [W-1:0] lo_q;

    assign op_e = mdu_op_e'(op_i);

    mdu_operand_prep #(.W(W)) u_prep (
        .op_i       (op_e),
        .a_i        (a_i),
        .b_i        (b_i),
        .mag_a_o    (mag_a),
        .mag_b_o    (mag_b),
        .neg_main_o (p_neg_main),
        .neg_a_o    (p_neg_a),
        .b_zero_o   (p_bz)
    );

    mdu_iter_step #(.W(W)) u_step (
        .is_div_i (st_q.is_div),
        .acc_i    (st_q.acc),
        .low_i    (st_q.low),
        .opnd_i   (st_q.opnd),
        .acc_o    (step_acc),
        .low_o    (step_low)
    );

    mdu_result_fix #(.W(W)) u_fix (
        .is_div_i   (st_q.is_div),
        .neg_main_i (st_q.neg_main),
        .neg_a_i    (st_q.neg_a),
        .b_zero_i   (st_q.bz),
        .a_orig_i   (st_q.a_orig),
        .acc_i      (st_q.acc),
        .low_i      (st_q.low),
        .hi_o       (fix_hi),
        .lo_o       (fix_lo)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph       = PH_RUN;
                    st_d.cnt      = '0;
                    st_d.is_div   = op_i[1];
                    st_d.neg_main = p_neg_main;
                    st_d.neg_a    = p_neg_a;
                    st_d.bz       = p_bz;
                    st_d.a_orig   = a_i;
                    st_d.acc      = '0;
                    st_d.low      = mag_a;
                    st_d.opnd     = mag_b;
                end
            end
            PH_RUN: begin
                st_d.acc = step_acc;
                st_d.low = step_low;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST) begin
                    st_d.ph = PH_FIX;
                end
            end
            PH_FIX: begin
                st_d.hi = fix_hi;
                st_d.lo = fix_lo;
                st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_q    = st_q.hi;
    assign lo_q    = st_q.lo;
    assign busy_o  = (st_q.ph != PH_IDLE);
    assign stall_o = busy_o & (rd_hi_i | rd_lo_i);
    assign rdata_o = rd_hi_i ? hi_q : (rd_lo_i ? lo_q : '0);

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic           op_div_i,
    input logic [W-1:0]   a_i,
    input logic [W-1:0]   b_i,
    input logic           rd_hi_i,
    input logic           rd_lo_i,
    input logic           busy_o,
    input logic           stall_o,
    input logic [W-1:0]   rdata_o,
    input logic [W-1:0]   hi_q,
    input logic [W-1:0]   lo_q
);

    logic [15:0]  run_len;
    logic         cap_div;
    logic         cap_bz;
    logic [W-1:0] cap_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
            cap_div <= 1'b0;
            cap_bz  <= 1'b0;
            cap_a   <= '0;
        end else begin
            run_len <= busy_o ? run_len + 16'd1 : 16'd0;
            if (start_i && !busy_o) begin
                cap_div <= op_div_i;
                cap_bz  <= (b_i == '0);
                cap_a   <= a_i;
            end
        end
    end

    // R6
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R6
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == 16'(W + 1)));

    // R5
    div_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && cap_div && cap_bz) |-> (lo_q == '1 && hi_q == cap_a));

    // R9
    stall_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (busy_o && (rd_hi_i || rd_lo_i)));

    // R9
    read_stable_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && rd_hi_i == $past(rd_hi_i)
         && rd_lo_i == $past(rd_lo_i)) |-> $stable(rdata_o));

    // R10
    hilo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy_o) |-> ($stable(hi_q) && $stable(lo_q)));

endmodule

bind muldiv_hilo mdu_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_div_i (op_i[1]),
    .a_i      (a_i),
    .b_i      (b_i),
    .rd_hi_i  (rd_hi_i),
    .rd_lo_i  (rd_lo_i),
    .busy_o   (busy_o),
    .stall_o  (stall_o),
    .rdata_o  (rdata_o),
    .hi_q     (hi_q),
    .lo_q     (lo_q)
);

// File: tb/muldiv_hilo_tb.sv
module muldiv_hilo_tb;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         rd_hi_i;
    logic         rd_lo_i;
    logic         busy_o;
    logic         stall_o;
    logic [W-1:0] rdata_o;

    logic mon_rd_hi = 1'b0, mon_rd_lo = 1'b0;
    logic drv_rd_hi = 1'b0, drv_rd_lo = 1'b0;
    assign rd_hi_i = mon_rd_hi | drv_rd_hi;
    assign rd_lo_i = mon_rd_lo | drv_rd_lo;

    always #10 clk = ~clk;

    muldiv_hilo #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .rd_hi_i(rd_hi_i), .rd_lo_i(rd_lo_i),
        .busy_o(busy_o), .stall_o(stall_o), .rdata_o(rdata_o)
    );

    typedef struct {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        string        tag;
    } exp_t;

    exp_t         exp_q[$];
    int           n_tests = 0;
    int           n_fail = 0;
    int           done_cnt = 0;
    logic [W-1:0] last_hi = '0;
    logic [W-1:0] last_lo = '0;

    task automatic chk(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [1:0] op, input logic [W-1:0] a,
                                   input logic [W-1:0] b, input string tag);
        exp_t e;
        logic [63:0] p;
        longint sa, sb, q, r;
        e.tag = tag;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (op)
            2'b00: begin p = 64'(sa * sb); e.hi = p[63:32]; e.lo = p[31:0]; end
            2'b01: begin p = {32'b0, a} * {32'b0, b}; e.hi = p[63:32]; e.lo = p[31:0]; end
            2'b10: begin
                if (b == '0) begin e.hi = a; e.lo = '1; end
                else begin
                    q = sa / sb; r = sa % sb;
                    e.hi = r[31:0]; e.lo = q[31:0];
                end
            end
            default: begin
                if (b == '0) begin e.hi = a; e.lo = '1; end
                else begin e.hi = a % b; e.lo = a / b; end
            end
        endcase
        return e;
    endfunction

    // Monitor: on busy falling, read HI then LO and compare with scoreboard
    initial begin
        logic prev_busy;
        exp_t e;
        logic [W-1:0] got;
        prev_busy = 1'b0;
        forever begin
            @(negedge clk);
            if (prev_busy && !busy_o && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                mon_rd_hi = 1'b1;
                #1 got = rdata_o;
                chk(got == e.hi, {e.tag, " HI"}, got, e.hi);
                mon_rd_hi = 1'b0;
                mon_rd_lo = 1'b1;
                #1 got = rdata_o;
                chk(got == e.lo, {e.tag, " LO"}, got, e.lo);
                mon_rd_lo = 1'b0;
                last_hi = e.hi;
                last_lo = e.lo;
                done_cnt++;
            end
            prev_busy = busy_o;
        end
    end

    task automatic run_op(input logic [1:0] op, input logic [W-1:0] a,
                          input logic [W-1:0] b, input string tag,
                          input bit poke, input bit busy_read);
        int len;
        int target;
        logic [W-1:0] old_hi, old_lo;
        target = done_cnt + 1;
        old_hi = last_hi;
        old_lo = last_lo;
        exp_q.push_back(model(op, a, b, tag));
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R6 busy after start", {31'b0, busy_o}, 32'd1);
        len = 0;
        while (busy_o) begin
            len++;
            if (poke && len == 5) begin
                start_i = 1'b1; op_i = ~op; a_i = ~a; b_i = a ^ b;
            end else begin
                start_i = 1'b0;
            end
            if (busy_read && len == 10) begin
                drv_rd_hi = 1'b1;
                #1;
                chk(stall_o == 1'b1, "R9 stall on HI read", {31'b0, stall_o}, 32'd1);
                chk(rdata_o == old_hi, "R9 old HI while busy", rdata_o, old_hi);
                drv_rd_hi = 1'b0;
                drv_rd_lo = 1'b1;
                #1;
                chk(rdata_o == old_lo, "R9 old LO while busy", rdata_o, old_lo);
                drv_rd_lo = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(len == W + 1, "R6 busy length", 32'(len), 32'(W + 1));
        wait (done_cnt == target);
        if (poke) begin
            @(negedge clk);
            chk(busy_o == 1'b0, "R7 no second run", {31'b0, busy_o}, 32'd0);
        end
    endtask

    task automatic finish_up;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog: actual running expected finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy_o == 1'b0, "R1 busy in reset", {31'b0, busy_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy after reset", {31'b0, busy_o}, 32'd0);
        drv_rd_hi = 1'b1; #1;
        chk(rdata_o == '0, "R1 HI zero", rdata_o, '0);
        chk(stall_o == 1'b0, "R1 stall low", {31'b0, stall_o}, 32'd0);
        drv_rd_hi = 1'b0; drv_rd_lo = 1'b1; #1;
        chk(rdata_o == '0, "R1 LO zero", rdata_o, '0);
        drv_rd_lo = 1'b0;

        // R2 multiplies
        run_op(2'b00, 32'hFFFF_FFF9, 32'd6, "R2 smul neg*pos", 0, 0);
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R2 smul min*min", 0, 1);
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 umul max*max", 0, 1);
        run_op(2'b00, 32'h1234_5678, 32'd0, "R2 smul by zero", 0, 0);
        // R3 unsigned divides
        run_op(2'b11, 32'hFFFF_FFFF, 32'd7, "R3 udiv", 0, 1);
        run_op(2'b11, 32'd5, 32'd9, "R3 udiv small", 0, 0);
        // R4 signed divides
        run_op(2'b10, 32'hFFFF_FFF9, 32'd2, "R4 sdiv -7/2", 0, 0);
        run_op(2'b10, 32'd7, 32'hFFFF_FFFE, "R4 sdiv 7/-2", 0, 0);
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R4 sdiv min/-1", 0, 0);
        // R5 divide by zero
        run_op(2'b10, 32'hFFFF_FF00, 32'd0, "R5 sdiv by zero", 0, 1);
        run_op(2'b11, 32'hDEAD_BEEF, 32'd0, "R5 udiv by zero", 0, 0);
        // R7 start while busy ignored
        run_op(2'b01, 32'h0001_0003, 32'h0002_0005, "R7 umul with poke", 1, 1);

        // R8 read select in idle
        @(negedge clk);
        drv_rd_hi = 1'b1; drv_rd_lo = 1'b1; #1;
        chk(rdata_o == last_hi, "R8 both requests give HI", rdata_o, last_hi);
        chk(stall_o == 1'b0, "R9 no stall when idle", {31'b0, stall_o}, 32'd0);
        drv_rd_hi = 1'b0; #1;
        chk(rdata_o == last_lo, "R8 LO request", rdata_o, last_lo);
        drv_rd_lo = 1'b0; #1;
        chk(rdata_o == '0, "R8 no request gives zero", rdata_o, '0);
        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule